// File: doc/BRIEF.md
# PCI Host Controller Register Interface

This block is the CPU-facing register slave of an on-chip PCI host bridge. A simple 32-bit CPU bus port reaches a 0x224-byte register window. The window holds the bridge's own 256-byte configuration header and a configuration address register. It also holds a memory base register, an I/O base register and a data port. An access to the data port turns into a configuration read or write cycle on a request/acknowledge master port. The CPU access is stalled until the target answers.

The I/O base register places a relocatable 256 KB I/O window in the CPU address space. A decoder compares a probe address against the stored base. It flags a hit and gives the offset into the window. The block also routes device interrupt levels. Each level event carries a device/function code. The device number is the code shifted right by three, and it selects one of four interrupt outputs, which keep the last level they were given.

Top module: `pcih_regif`

## Requirements
- R1: After reset, the configuration address and memory base registers read 0 and the I/O base register reads 0xFE240000. Header word at offset 0x004 reads 0x02900080, which is the command word 0x0080 (wait-cycle bit 7) in bits 15:0 and the status word 0x0290 (capability list bit 4, fast back-to-back bit 7, medium select timing 0x0200) in bits 31:16. All other header words read 0 and all interrupt outputs are low.
- R2: Offsets 0x000 to 0x0FC read and write the 64 words of the local header. Byte 0 of each word is bits 7:0.
- R3: Offset 0x1C0 stores the full 32-bit written value and reads it back unchanged.
- R4: Offset 0x1C4 keeps only bits 31:24 and bit 0 of a write. All other bits read 0.
- R5: Offset 0x1C8 keeps only bits 31:18 and bit 0. A write whose bits 31:18 equal the stored bits 31:18 is ignored completely, including its bit 0.
- R6: io_hit is high exactly when io_probe_addr[31:18] equals I/O base bits 31:18. io_offset is always io_probe_addr[17:0].
- R7: A read of offset 0x220 raises cfg_req with cfg_we=0 and cfg_addr equal to the configuration address register, on the clock after the access is presented. cpu_ready stays low until cfg_ack is seen, and in that cycle cpu_rdata equals cfg_rdata.
- R8: A write of offset 0x220 issues the same cycle with cfg_we=1 and cfg_wdata equal to the CPU write data. The payload stays stable while the request waits.
- R9: A read of an unmapped offset (0x100–0x1BC, 0x1CC–0x21C, 0x224 and above) or of a non-word-aligned offset returns 0. A write to such an offset changes no register.
- R10: A pulse on irq_strobe sets irq_out[irq_devfn>>3] to irq_level on the next clock, provided the device number is below 4. Other outputs are unchanged, and device numbers of 4 or more change nothing.
- R11: Every access other than to offset 0x220 completes in the cycle it is presented, with cpu_ready high and read data valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Byte offset into the register window |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid when cpu_ready |
| cpu_ready | output | 1 | Access completes on this clock |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_addr | output | 32 | Configuration cycle address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| cfg_ack | input | 1 | Configuration cycle done |
| io_probe_addr | input | 32 | CPU address to test against the I/O window |
| io_hit | output | 1 | Probe address is inside the I/O window |
| io_offset | output | 18 | Offset of the probe into the window |
| irq_strobe | input | 1 | Interrupt level event |
| irq_devfn | input | 8 | Device/function code of the event |
| irq_level | input | 1 | New interrupt level |
| irq_out | output | 4 | Routed interrupt levels |

## Verification
Register accesses are due in the cycle they are presented. The bench counts the falling edges until cpu_ready and expects exactly one. A data-port access is due lat+2 falling edges after it is presented, where lat is the delay the bench target inserts before acknowledging. The check compares the measured wait against that count for latencies 0 to 3.

Read data is taken by a monitor at the falling edge where cpu_ready is first seen and compared against a queue filled by the driver. Interrupt outputs are registered and are sampled on the falling edge after the clock that took the strobe. The I/O decoder is combinational and is sampled half a cycle after its probe address changes.

// File: rtl/pcih_pkg.sv
`timescale 1ns/1ps
package pcih_pkg;

  localparam logic [31:0] MBASE_KEEP  = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_KEEP = 32'hFFFC_0001;
  localparam logic [31:0] IOBASE_RST  = 32'hFE24_0000;
  localparam logic [15:0] CMD_RST     = 16'h0080;
  localparam logic [15:0] STAT_RST    = 16'h0290;
  localparam int          IOWIN_BITS  = 18;

  typedef enum logic [2:0] {
    RG_HDR, RG_CADDR, RG_MBASE, RG_IOBASE, RG_CDATA, RG_NONE
  } region_e;

  function automatic region_e region_of(input logic [11:0] off);
    if (off[1:0] != 2'b00)       return RG_NONE;
    else if (off < 12'h100)      return RG_HDR;
    else if (off == 12'h1C0)     return RG_CADDR;
    else if (off == 12'h1C4)     return RG_MBASE;
    else if (off == 12'h1C8)     return RG_IOBASE;
    else if (off == 12'h220)     return RG_CDATA;
    else                         return RG_NONE;
  endfunction

  function automatic logic [31:0] hdr_reset_word(input int idx);
    return (idx == 1) ? {STAT_RST, CMD_RST} : 32'h0;
  endfunction

  function automatic logic [31:0] keep_mbase(input logic [31:0] v);
    return v & MBASE_KEEP;
  endfunction

  function automatic logic [31:0] keep_iobase(input logic [31:0] v);
    return v & IOBASE_KEEP;
  endfunction

  function automatic logic iobase_moves(input logic [31:0] cur, input logic [31:0] nxt);
    return cur[31:IOWIN_BITS] != nxt[31:IOWIN_BITS];
  endfunction

  function automatic logic [4:0] dev_of(input logic [7:0] devfn);
    return 5'(devfn >> 3);
  endfunction

endpackage

// File: rtl/pcih_hdr_regs.sv
`timescale 1ns/1ps
module pcih_hdr_regs #(
  parameter int WORDS = 64,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  import pcih_pkg::*;

  logic [31:0] words [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                   words[i] <= hdr_reset_word(i);
      else if (wr_en && (wr_idx == IW'(i)))         words[i] <= wr_data;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/pcih_cfg_master.sv
`timescale 1ns/1ps
module pcih_cfg_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  input  logic [31:0] start_addr,
  input  logic [31:0] start_wdata,
  output logic        idle,
  output logic        done,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [31:0] cfg_addr,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q      <= ST_WAIT;
          cfg_we    <= start_we;
          cfg_addr  <= start_addr;
          cfg_wdata <= start_wdata;
        end
        ST_WAIT: if (cfg_ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign cfg_req = (st_q == ST_WAIT);
  assign done    = cfg_req && cfg_ack;

  // R7: an unanswered request stays up
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req);
  // R8: payload frozen while waiting
  a_r8_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_we));
endmodule

// File: rtl/pcih_io_window.sv
`timescale 1ns/1ps
module pcih_io_window (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [31:0]                      wr_data,
  input  logic [31:0]                      probe,
  output logic [31:0]                      base,
  output logic                             hit,
  output logic [pcih_pkg::IOWIN_BITS-1:0]  offset
);
  import pcih_pkg::*;

  logic take;
  assign take = wr_en && iobase_moves(base, wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n)    base <= IOBASE_RST;
    else if (take) base <= keep_iobase(wr_data);
  end

  assign hit    = (probe[31:IOWIN_BITS] == base[31:IOWIN_BITS]);
  assign offset = probe[IOWIN_BITS-1:0];

  // R5: a write keeping the upper bits leaves the register alone
  a_r5_same_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_data[31:IOWIN_BITS] == base[31:IOWIN_BITS]) |=> $stable(base));
endmodule

// File: rtl/pcih_irq_route.sv
`timescale 1ns/1ps
module pcih_irq_route #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic [7:0]         devfn,
  input  logic               level,
  output logic [NUM_IRQ-1:0] irq
);
  import pcih_pkg::*;

  logic [4:0] dev;
  assign dev = dev_of(devfn);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                          irq[i] <= 1'b0;
      else if (strobe && dev == 5'(i))     irq[i] <= level;
    end
  end

  // R10: lines move only on a strobe
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(irq));
  // R10: one strobe touches at most one line
  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> $countones(irq ^ $past(irq)) <= 1);
  // R10: out-of-range device numbers are dropped
  a_r10_far_dev_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (dev >= 5'(NUM_IRQ)) |=> $stable(irq));
endmodule

// File: rtl/pcih_regif.sv
`timescale 1ns/1ps
module pcih_regif #(
  parameter int ADDR_W  = 10,
  parameter int NUM_IRQ = 4,
  parameter int HDR_WORDS = 64,
  localparam int HIW = $clog2(HDR_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  output logic               cpu_ready,
  output logic               cfg_req,
  output logic               cfg_we,
  output logic [31:0]        cfg_addr,
  output logic [31:0]        cfg_wdata,
  input  logic [31:0]        cfg_rdata,
  input  logic               cfg_ack,
  input  logic [31:0]        io_probe_addr,
  output logic               io_hit,
  output logic [17:0]        io_offset,
  input  logic               irq_strobe,
  input  logic [7:0]         irq_devfn,
  input  logic               irq_level,
  output logic [NUM_IRQ-1:0] irq_out
);
  import pcih_pkg::*;

  region_e     region;
  logic        wr_acc;
  logic [31:0] caddr_q, mbase_q, iobase;
  logic [31:0] hdr_rd;
  logic        cm_idle, cm_done, cm_start;

  assign region   = region_of(12'(cpu_addr));
  assign wr_acc   = cpu_sel && cpu_we;
  assign cm_start = cpu_sel && (region == RG_CDATA) && cm_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      caddr_q <= '0;
      mbase_q <= '0;
    end else begin
      if (wr_acc && region == RG_CADDR) caddr_q <= cpu_wdata;
      if (wr_acc && region == RG_MBASE) mbase_q <= keep_mbase(cpu_wdata);
    end
  end

  pcih_hdr_regs #(.WORDS(HDR_WORDS)) u_hdr (
    .clk, .rst_n,
    .wr_en  (wr_acc && region == RG_HDR),
    .wr_idx (cpu_addr[HIW+1:2]),
    .wr_data(cpu_wdata),
    .rd_idx (cpu_addr[HIW+1:2]),
    .rd_data(hdr_rd)
  );

  pcih_cfg_master u_cm (
    .clk, .rst_n,
    .start      (cm_start),
    .start_we   (cpu_we),
    .start_addr (caddr_q),
    .start_wdata(cpu_wdata),
    .idle       (cm_idle),
    .done       (cm_done),
    .cfg_req, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_ack
  );

  pcih_io_window u_iow (
    .clk, .rst_n,
    .wr_en  (wr_acc && region == RG_IOBASE),
    .wr_data(cpu_wdata),
    .probe  (io_probe_addr),
    .base   (iobase),
    .hit    (io_hit),
    .offset (io_offset)
  );

  pcih_irq_route #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk, .rst_n,
    .strobe(irq_strobe),
    .devfn (irq_devfn),
    .level (irq_level),
    .irq   (irq_out)
  );

  always_comb begin
    case (region)
      RG_HDR:    cpu_rdata = hdr_rd;
      RG_CADDR:  cpu_rdata = caddr_q;
      RG_MBASE:  cpu_rdata = mbase_q;
      RG_IOBASE: cpu_rdata = iobase;
      RG_CDATA:  cpu_rdata = cm_done ? cfg_rdata : 32'h0;
      default:   cpu_rdata = 32'h0;
    endcase
  end

  assign cpu_ready = cpu_sel && ((region != RG_CDATA) || cm_done);

  // R7: the CPU is held while the target has not answered
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |-> !cpu_ready);
  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sel && !cpu_we && (region == RG_NONE) |-> cpu_rdata == 32'h0);
  // R4: memory base never holds bits outside its kept set
  a_r4_mbase_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && region == RG_MBASE |=> (mbase_q & ~MBASE_KEEP) == 32'h0);
  // R3: configuration address follows a write exactly
  a_r3_caddr_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && region == RG_CADDR |=> caddr_q == $past(cpu_wdata));
endmodule

// File: tb/pcih_regif_tb.sv
`timescale 1ns/1ps
module pcih_regif_tb;
  logic        clk = 0, rst_n = 0;
  logic        cpu_sel = 0, cpu_we = 0;
  logic [9:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        cpu_ready;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic        cfg_ack = 0;
  logic [31:0] io_probe_addr = '0;
  logic        io_hit;
  logic [17:0] io_offset;
  logic        irq_strobe = 0, irq_level = 0;
  logic [7:0]  irq_devfn = '0;
  logic [3:0]  irq_out;

  localparam logic [31:0] TGT_KEY = 32'h5A5A_0F0F;

  int checks = 0, fails = 0, cfg_lat = 0;
  bit finished = 0;
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [31:0] ca_exp_q[$], cd_exp_q[$];
  logic        cw_exp_q[$];
  logic [3:0]  irq_model = '0;
  logic [31:0] caddr_model = '0;

  always #2 clk = ~clk;

  pcih_regif u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor: one pop per completed read
  always @(negedge clk) begin
    if (rst_n && cpu_sel && !cpu_we && cpu_ready) begin
      if (rd_exp_q.size() == 0) check("SCOREBOARD unexpected read", cpu_rdata, 32'hx);
      else check(rd_tag_q.pop_front(), cpu_rdata, rd_exp_q.pop_front());
    end
  end

  // configuration target model
  initial begin
    forever begin
      @(posedge clk); #1;
      if (cfg_req) begin
        if (ca_exp_q.size() == 0) check("R7 unexpected cfg_req", 32'h1, 32'h0);
        else begin
          logic w;
          logic [31:0] d;
          w = cw_exp_q.pop_front();
          d = cd_exp_q.pop_front();
          check("R7/R8 cfg_addr", cfg_addr, ca_exp_q.pop_front());
          check("R7/R8 cfg_we", 32'(cfg_we), 32'(w));
          if (w) check("R8 cfg_wdata", cfg_wdata, d);
        end
        repeat (cfg_lat) @(posedge clk);
        #1; cfg_ack = 1; cfg_rdata = cfg_addr ^ TGT_KEY;
        @(posedge clk); #1; cfg_ack = 0; cfg_rdata = '0;
      end
    end
  end

  task automatic access(input logic we, input logic [9:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag, input int exp_waits);
    int waits = 0;
    if (!we) begin rd_exp_q.push_back(exp); rd_tag_q.push_back(tag); end
    @(posedge clk); #1;
    cpu_sel = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    forever begin
      @(negedge clk); waits++;
      if (cpu_ready || waits > 50) break;
    end
    check({tag, " ready timing"}, 32'(waits), 32'(exp_waits));
    @(posedge clk); #1;
    cpu_sel = 0; cpu_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    access(0, a, 0, exp, tag, 1);
  endtask
  task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    access(1, a, d, 0, tag, 1);
  endtask

  task automatic cfg_rd(input int lat);
    cfg_lat = lat;
    ca_exp_q.push_back(caddr_model); cw_exp_q.push_back(0); cd_exp_q.push_back(0);
    access(0, 10'h220, 0, caddr_model ^ TGT_KEY, "R7 cfg read data", lat + 2);
  endtask
  task automatic cfg_wr(input int lat, input logic [31:0] d);
    cfg_lat = lat;
    ca_exp_q.push_back(caddr_model); cw_exp_q.push_back(1); cd_exp_q.push_back(d);
    access(1, 10'h220, d, 0, "R8 cfg write", lat + 2);
  endtask

  task automatic probe(input logic [31:0] a, input logic hit, input string tag);
    io_probe_addr = a;
    @(negedge clk);
    check({tag, " io_hit"}, 32'(io_hit), 32'(hit));
    check({tag, " io_offset"}, 32'(io_offset), 32'(a[17:0]));
  endtask

  task automatic irq_ev(input logic [7:0] devfn, input logic lvl);
    @(posedge clk); #1;
    irq_strobe = 1; irq_devfn = devfn; irq_level = lvl;
    @(posedge clk); #1;
    irq_strobe = 0;
    if ((devfn >> 3) < 4) irq_model[devfn >> 3] = lvl;
    @(negedge clk);
    check("R10 irq_out", 32'(irq_out), 32'(irq_model));
  endtask

  initial begin
    #(4 * 150000);
    check("WATCHDOG expired", 32'h1, 32'h0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 irq_out reset", 32'(irq_out), 32'h0);
    // R1 reset values
    rd(10'h004, 32'h0290_0080, "R1 header cmd/status");
    rd(10'h000, 32'h0, "R1 header word0");
    rd(10'h0FC, 32'h0, "R1 header last word");
    rd(10'h1C0, 32'h0, "R1 cfg addr");
    rd(10'h1C4, 32'h0, "R1 mem base");
    rd(10'h1C8, 32'hFE24_0000, "R1 io base");
    probe(32'hFE27_FFFC, 1, "R6 default top");
    probe(32'hFE28_0000, 0, "R6 default past end");
    probe(32'hFE23_FFFF, 0, "R6 default below");
    // R2 header words
    wr(10'h0FC, 32'hDEAD_BEEF, "R2 hdr write");
    wr(10'h010, 32'h1122_3344, "R2 hdr write");
    rd(10'h0FC, 32'hDEAD_BEEF, "R2 hdr last");
    rd(10'h010, 32'h1122_3344, "R2 hdr mid");
    rd(10'h004, 32'h0290_0080, "R2 neighbour untouched");
    // R3
    wr(10'h1C0, 32'h8000_1234, "R3 write");
    caddr_model = 32'h8000_1234;
    rd(10'h1C0, 32'h8000_1234, "R3 readback");
    // R4
    wr(10'h1C4, 32'hFFFF_FFFF, "R4 write");
    rd(10'h1C4, 32'hFF00_0001, "R4 all ones");
    wr(10'h1C4, 32'h1234_5678, "R4 write");
    rd(10'h1C4, 32'h1200_0000, "R4 pattern");
    // R5
    wr(10'h1C8, 32'hFE24_0001, "R5 write");
    rd(10'h1C8, 32'hFE24_0000, "R5 bit0-only ignored");
    wr(10'h1C8, 32'h1234_5678, "R5 write");
    rd(10'h1C8, 32'h1234_0000, "R5 moved");
    probe(32'h1234_1ABC, 1, "R6 moved hit");
    probe(32'h1238_0000, 0, "R6 moved miss");
    probe(32'hFE24_0000, 0, "R6 old base miss");
    wr(10'h1C8, 32'h1237_FFFF, "R5 write");
    rd(10'h1C8, 32'h1234_0000, "R5 same upper ignored");
    wr(10'h1C8, 32'hFE24_0001, "R5 write");
    rd(10'h1C8, 32'hFE24_0001, "R5 moved with bit0");
    // R7 / R8
    cfg_rd(0);
    cfg_rd(3);
    cfg_wr(2, 32'hCAFE_F00D);
    wr(10'h1C0, 32'h0000_0A5C, "R3 write");
    caddr_model = 32'h0000_0A5C;
    cfg_wr(0, 32'h0BAD_1DEA);
    cfg_rd(1);
    // R9 unmapped and misaligned
    rd(10'h100, 32'h0, "R9 unmapped 0x100");
    rd(10'h1CC, 32'h0, "R9 unmapped 0x1CC");
    rd(10'h224, 32'h0, "R9 past window");
    rd(10'h3FC, 32'h0, "R9 top offset");
    rd(10'h1C2, 32'h0, "R9 misaligned");
    wr(10'h1C2, 32'hFFFF_FFFF, "R9 misaligned write");
    wr(10'h001, 32'hFFFF_FFFF, "R9 misaligned hdr write");
    wr(10'h100, 32'h7777_7777, "R9 unmapped write");
    rd(10'h1C0, 32'h0000_0A5C, "R9 cfg addr kept");
    rd(10'h000, 32'h0, "R9 header kept");
    rd(10'h100, 32'h0, "R9 unmapped still zero");
    // R10 interrupt routing
    irq_ev(8'h00, 1);
    irq_ev(8'h1F, 1);
    irq_ev(8'h0A, 1);
    irq_ev(8'h00, 0);
    irq_ev(8'h20, 1);
    irq_ev(8'hF8, 1);
    irq_ev(8'h17, 0);
    repeat (4) @(posedge clk);
    check("R7 cfg queue drained", 32'(ca_exp_q.size()), 32'h0);
    check("R11 read queue drained", 32'(rd_exp_q.size()), 32'h0);
    summary();
  end
endmodule